// File: doc/BRIEF.md
# Double-Buffered Colour Lookup Table

This block turns an 8-bit pixel index into a 24-bit RGB colour for the display pipe. It holds two banks of palette entries. The display reads only the live bank. Software writes and reads only the other bank, through a byte-addressed register window. A new palette is therefore built off-screen, and the display never shows a half-written table.

To make the new palette visible, software writes the control word with the switch bit inverted. The block keeps the displayed bank unchanged until the next vertical-blank strobe. On that strobe the displayed bank flips, and the read-only status bit takes the value of the switch bit. While the two bits differ, a swap is pending. Once they match again, the old live bank has become the editable one. Software must then refill it completely before it requests another swap.

Top module: `clut_dbuf`

## Requirements
- R1: After reset, `pixRgb` is 0 and a read of the control word returns 0: switch bit 0, status bit 0, bank 0 displayed.
- R2: Palette entry n is written at byte address 4n. Bits [1:0] of the address are ignored. The entry is 24 bits: red in [23:16], green in [15:8] and blue in [7:0]. A write always lands in the bank that is not displayed, so `pixRgb` does not change.
- R3: A register read takes one cycle. A read of a palette address returns that entry from the non-displayed bank in bits [23:0], with bits [31:24] zero.
- R4: Index presented on `pixIdx` in one cycle appears as the displayed bank's entry on `pixRgb` after the next clock edge. A new index may be given every cycle.
- R5: The control word sits at byte address 4·ENTRIES (0x400 by default). Bit 0 is the switch bit, which can be read and written. Bit 1 is the status bit, which is read-only: writes to it are ignored. All other bits read as 0.
- R6: Changing the switch bit does not change the displayed bank or the status bit. On the next `vblankStb` cycle, with the two bits differing, the status bit takes the switch value and the displayed bank flips. The lookup in that same cycle still uses the old bank.
- R7: A `vblankStb` pulse while the switch and status bits agree changes neither the status bit nor the displayed bank.
- R8: Reads of word addresses above the control word return 0. Writes to them change neither palette bank nor the control word.
- R9: A palette write in the same cycle as a swapping `vblankStb` goes to the bank that was non-displayed before that edge. That bank is the newly displayed one after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and register clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W (11) | Byte address into the register window |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | BUS_W (32) | Register write data |
| regRdEn | input | 1 | Register read strobe |
| regRdData | output | BUS_W (32) | Read data, valid the cycle after `regRdEn` |
| pixIdx | input | IDX_W (8) | Pixel palette index |
| pixRgb | output | RGB_W (24) | Looked-up colour, one cycle after the index |
| vblankStb | input | 1 | One-cycle vertical blank strobe |

## Verification
The bench uses the default parameters: 256 entries, 24-bit colour and a 32-bit bus. It can therefore fill whole banks and reach both edges of the palette (entries 0 and 255). It also reaches the control word at 0x400 and the unmapped words above it. Both banks are loaded with distinct patterns and two swaps are made, so every check can tell which bank answered. One check coincides a palette write with a swapping strobe (R9). Others pulse the strobe with no swap pending (R7) and write the read-only status bit (R5).

// File: rtl/clut_pkg.sv
`timescale 1ns/1ps
package clut_pkg;
  // Strobes from the control unit to the palette datapath
  typedef struct packed {
    logic lutWr;   // write palette entry
    logic lutRd;   // read palette entry
    logic ctrlRd;  // read control word
    logic anyRd;   // any read request
    logic wrBank;  // bank receiving software writes / reads
  } clut_strb_t;
endpackage

// File: rtl/clut_ctrl.sv
`timescale 1ns/1ps
module clut_ctrl
  import clut_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int BUS_W   = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int ADDR_W = IDX_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [BUS_W-1:0]  regWrData,
  input  logic              regRdEn,
  input  logic              vblankStb,
  output clut_strb_t        strb,
  output logic              liveBank,
  output logic              swReq
);
  localparam int WORD_W = IDX_W + 1;
  localparam logic [WORD_W-1:0] CTRL_WORD = WORD_W'(ENTRIES);

  logic [WORD_W-1:0] wordIdx;
  logic isLut, isCtrl, ctrlWr;

  assign wordIdx = regAddr[ADDR_W-1:2];
  assign isLut   = (wordIdx < CTRL_WORD);
  assign isCtrl  = (wordIdx == CTRL_WORD);
  assign ctrlWr  = regWrEn && isCtrl;

  always_comb begin
    strb.lutWr  = regWrEn && isLut;
    strb.lutRd  = regRdEn && isLut;
    strb.ctrlRd = regRdEn && isCtrl;
    strb.anyRd  = regRdEn;
    strb.wrBank = ~liveBank;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swReq    <= 1'b0;
      liveBank <= 1'b0;
    end else begin
      if (ctrlWr) swReq <= regWrData[0];
      if (vblankStb && (swReq != liveBank)) liveBank <= swReq;
    end
  end

  // Displayed bank only moves on a vertical-blank strobe
  assert_flip_on_vblank_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(liveBank) |-> $past(vblankStb));

  // A pending request is honoured at the strobe
  assert_swap_taken_R6: assert property (@(posedge clk) disable iff (!rstN)
    (vblankStb && (swReq != liveBank)) |=> (liveBank == $past(swReq)));

  // No request pending: strobe leaves the bank alone
  assert_idle_vblank_R7: assert property (@(posedge clk) disable iff (!rstN)
    (vblankStb && (swReq == liveBank) && !ctrlWr) |=> $stable(liveBank));

  // Switch bit only changes through a control-word write
  assert_switch_by_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(swReq) |-> $past(regWrEn));
endmodule

// File: rtl/clut_datapath.sv
`timescale 1ns/1ps
module clut_datapath
  import clut_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int RGB_W   = 24,
  parameter int BUS_W   = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int ADDR_W = IDX_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  clut_strb_t        strb,
  input  logic              liveBank,
  input  logic              swReq,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BUS_W-1:0]  regWrData,
  output logic [BUS_W-1:0]  regRdData,
  input  logic [IDX_W-1:0]  pixIdx,
  output logic [RGB_W-1:0]  pixRgb
);
  logic [IDX_W-1:0] regIdx;
  logic [RGB_W-1:0] pixLook [2];
  logic [RGB_W-1:0] regLook [2];

  assign regIdx = regAddr[IDX_W+1:2];

  for (genvar b = 0; b < 2; b++) begin : gBank
    logic [RGB_W-1:0] mem [ENTRIES];
    always_ff @(posedge clk) begin
      if (strb.lutWr && (strb.wrBank == 1'(b)))
        mem[regIdx] <= regWrData[RGB_W-1:0];
    end
    assign pixLook[b] = mem[pixIdx];
    assign regLook[b] = mem[regIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixRgb    <= '0;
      regRdData <= '0;
    end else begin
      pixRgb <= pixLook[liveBank];
      if (strb.lutRd)
        regRdData <= BUS_W'(regLook[strb.wrBank]);
      else if (strb.ctrlRd)
        regRdData <= BUS_W'({liveBank, swReq});
      else
        regRdData <= '0;
    end
  end

  // Palette read-back carries no bits above the colour field
  assert_lut_read_width_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.lutRd) |-> (regRdData[BUS_W-1:RGB_W] == '0));

  // Control read-back exposes only the two defined bits
  assert_ctrl_read_fields_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.ctrlRd) |-> (regRdData[BUS_W-1:2] == '0));

  // Unmapped reads return zero
  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.anyRd) && !$past(strb.lutRd) && !$past(strb.ctrlRd)) |-> (regRdData == '0));
endmodule

// File: rtl/clut_dbuf.sv
`timescale 1ns/1ps
module clut_dbuf
  import clut_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int RGB_W   = 24,
  parameter int BUS_W   = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int ADDR_W = IDX_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [BUS_W-1:0]  regWrData,
  input  logic              regRdEn,
  output logic [BUS_W-1:0]  regRdData,
  input  logic [IDX_W-1:0]  pixIdx,
  output logic [RGB_W-1:0]  pixRgb,
  input  logic              vblankStb
);
  clut_strb_t strb;
  logic liveBank, swReq;

  clut_ctrl #(.ENTRIES(ENTRIES), .BUS_W(BUS_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .vblankStb(vblankStb),
    .strb(strb), .liveBank(liveBank), .swReq(swReq)
  );

  clut_datapath #(.ENTRIES(ENTRIES), .RGB_W(RGB_W), .BUS_W(BUS_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .liveBank(liveBank), .swReq(swReq),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .pixIdx(pixIdx), .pixRgb(pixRgb)
  );
endmodule

// File: tb/sim_clut_dbuf.sv
`timescale 1ns/1ps
module sim_clut_dbuf;
  localparam int ENTRIES = 256;
  localparam int ADDR_W  = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic regWrEn = 1'b0, regRdEn = 1'b0, vblankStb = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [7:0]  pixIdx = '0;
  logic [23:0] pixRgb;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [23:0] model [2][ENTRIES];
  bit mLive = 0, mSw = 0;

  always #2 clk = ~clk;

  clut_dbuf u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .pixIdx(pixIdx), .pixRgb(pixRgb), .vblankStb(vblankStb)
  );

  function automatic logic [23:0] pat(int b, int n);
    return {8'(n), 8'(255 - n), 8'(n) ^ (b != 0 ? 8'h3C : 8'hC3)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; regRdEn = 1'b1;
    @(negedge clk); regRdEn = 1'b0; d = regRdData;
  endtask

  task automatic pixLook(logic [7:0] i, output logic [23:0] d);
    @(negedge clk); pixIdx = i;
    @(negedge clk); d = pixRgb;
  endtask

  task automatic vblank();
    @(negedge clk); vblankStb = 1'b1;
    @(negedge clk); vblankStb = 1'b0;
    if (mSw != mLive) mLive = mSw;
  endtask

  task automatic fillInactive();
    for (int n = 0; n < ENTRIES; n++) begin
      // R2: entry n at byte 4n, low address bits ignored
      regWrite(ADDR_W'(4*n + (n % 4)), {8'hEE, pat(!mLive, n)});
      model[!mLive][n] = pat(!mLive, n);
    end
  endtask

  task automatic testReset();
    logic [31:0] d;
    chk("R1 pixRgb", 32'(pixRgb), 0);
    regRead(11'h400, d);
    chk("R1 ctrl", d, 0);
  endtask

  task automatic testFirstFill();
    logic [31:0] d;
    fillInactive();
    regRead(11'h000, d); chk("R3 entry0", d, 32'(model[1][0]));
    regRead(11'h3FC, d); chk("R3 entry255", d, 32'(model[1][255]));
    regRead(11'h200, d); chk("R2 entry128", d, 32'(model[1][128]));
  endtask

  task automatic testSwap();
    logic [31:0] d; logic [23:0] p;
    mSw = ~mSw; regWrite(11'h400, 32'(mSw));
    regRead(11'h400, d); chk("R6 pending", d, {30'b0, mLive, mSw});
    vblank();
    regRead(11'h400, d); chk("R6 status after vblank", d, {30'b0, mLive, mSw});
    pixLook(8'd7, p); chk("R6 live bank entry", 32'(p), 32'(model[mLive][7]));
  endtask

  task automatic testPixStream();
    logic [23:0] p;
    @(negedge clk); pixIdx = 8'd0;
    for (int i = 1; i < 6; i++) begin
      @(negedge clk);
      chk("R4 stream", 32'(pixRgb), 32'(model[mLive][(i-1)*51]));
      pixIdx = 8'(i*51);
    end
    @(negedge clk); chk("R4 stream last", 32'(pixRgb), 32'(model[mLive][255]));
  endtask

  task automatic testWriteHidden();
    logic [23:0] p; logic [31:0] d;
    fillInactive();
    pixLook(8'd9, p); chk("R2 display unchanged", 32'(p), 32'(model[mLive][9]));
    regRead(11'h024, d); chk("R3 inactive readback", d, 32'(model[!mLive][9]));
  endtask

  task automatic testIdleVblank();
    logic [31:0] d; logic [23:0] p;
    vblank();
    regRead(11'h400, d); chk("R7 no swap", d, {30'b0, mLive, mSw});
    pixLook(8'd200, p); chk("R7 same bank", 32'(p), 32'(model[mLive][200]));
  endtask

  task automatic testStatusRo();
    logic [31:0] d;
    regWrite(11'h400, {30'b0, ~mLive, mSw});
    regRead(11'h400, d); chk("R5 status read-only", d, {30'b0, mLive, mSw});
  endtask

  task automatic testUnmapped();
    logic [31:0] d; logic [23:0] p;
    regWrite(11'h404, 32'hFFFF_FFFF);
    regWrite(11'h7FC, 32'h0000_0000);
    regRead(11'h404, d); chk("R8 unmapped read", d, 0);
    regRead(11'h400, d); chk("R8 ctrl untouched", d, {30'b0, mLive, mSw});
    regRead(11'h010, d); chk("R8 inactive untouched", d, 32'(model[!mLive][4]));
    pixLook(8'd4, p); chk("R8 live untouched", 32'(p), 32'(model[mLive][4]));
  endtask

  task automatic testWriteAtFlip();
    logic [31:0] d; logic [23:0] p;
    mSw = ~mSw; regWrite(11'h400, 32'(mSw));
    @(negedge clk);
    regAddr = 11'h0C8; regWrData = 32'h00_123456; regWrEn = 1'b1; vblankStb = 1'b1;
    @(negedge clk); regWrEn = 1'b0; vblankStb = 1'b0;
    model[!mLive][50] = 24'h123456;
    mLive = mSw;
    pixLook(8'd50, p); chk("R9 write reached new live", 32'(p), 32'h123456);
    regRead(11'h0C8, d); chk("R9 old bank kept", d, 32'(model[!mLive][50]));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFirstFill();
    testSwap();
    testPixStream();
    testWriteHidden();
    testIdleVblank();
    testStatusRo();
    testSwap();
    testPixStream();
    testUnmapped();
    testWriteAtFlip();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule